// File: doc/BRIEF.md
# PCI Interrupt Steering Router

The router takes the four interrupt pins (A to D) of several PCI device slots and folds them onto four shared interrupt lines. Each slot's pins are rotated by its device number, so the first pin of neighbouring slots lands on different shared lines. The levels of the shared lines are registered once per clock. Four byte-wide steering registers then send each shared line to one of sixteen legacy interrupt outputs, or to none.

Each output is the OR of every registered shared-line level that is steered to it. The output path after the level register is purely combinational. Rewriting a steering byte therefore moves an asserted interrupt to its new output in the same cycle the register takes the new value.

Software reaches the steering registers through a small word-wide register port. The port has an 8-bit byte offset, 32-bit write data and per-byte enables, and reads are returned combinationally.

Top module: `pirq_router`

## Requirements
- R1: After reset, reading offset 0x60 returns 0x80808080, and every bit of `irq_o` is 0.
- R2: Pin p (0 = A … 3 = D) of a slot whose devfn byte is f lands on shared line (p + (f >> 3) − 1) mod 4. A devfn of 0x00 therefore sends pin A to line 3.
- R3: When pins of different slots land on the same shared line, their levels are ORed.
- R4: A steering byte below 16 selects the output with that number. A byte of 16 or more drives no output.
- R5: Each output is the OR of the levels of all shared lines whose steering byte names that output.
- R6: The steering bytes for lines 0..3 sit in byte lanes 0..3 of the word at offset 0x60. Offset bits [1:0] are ignored. A write changes only the lanes whose enable is set. Writes to any other word have no effect, and reads of any other word return 0.
- R7: A pin change reaches `irq_o` only after the next rising clock edge. Before that edge the output keeps its old value.
- R8: A steering write takes effect on `irq_o` directly after the edge that stores it, with no further delay.
- R9: Asserting `rst_ni` clears all registered line levels and restores every steering byte to 0x80, even while pins are held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_be_i | input | 4 | Write byte enables |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| slot_devfn_i | input | 8*N_SLOTS | devfn byte of each slot, slot 0 in the low byte |
| slot_pin_i | input | 4*N_SLOTS | Pin levels A..D of each slot, slot 0 in the low nibble |
| irq_o | output | N_OUT | Interrupt output levels |

## Verification
The bench builds the router with four slots and sixteen outputs. It gives the slots device numbers 1, 2, 3 and 0, so every rotation amount is exercised, including the wrap at device 0. With four slots, two slots can collide on one shared line and several lines can merge on one output. The sixteen outputs make both ends of the valid steering range (0 and 15) and the first out-of-range value (16) observable at the ports. A randomized phase then drives pins and steering writes together against the behavioural model, so that re-steering under live interrupts is covered.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned ROUTE_W   = 8;
  localparam logic [7:0]  ROUTE_RST = 8'h80;

  typedef logic [ROUTE_W-1:0] route_t;

  // rotation amount for a slot: device number minus one, modulo line count
  function automatic logic [1:0] slot_shift(input logic [7:0] devfn);
    logic [7:0] dev;
    dev = (devfn >> 3) - 8'd1;
    return dev[1:0];
  endfunction
endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import pirq_router_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4
) (
  input  logic [N_SLOTS*8-1:0] slot_devfn_i,
  input  logic [N_SLOTS*4-1:0] slot_pin_i,
  output logic [NUM_LINES-1:0] line_o
);
  logic [NUM_LINES-1:0] rot [N_SLOTS];

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [1:0] sh;
    assign sh = slot_shift(slot_devfn_i[s*8 +: 8]);
    always_comb begin
      rot[s] = '0;
      for (int p = 0; p < NUM_LINES; p++) begin
        rot[s][2'(p) + sh] = slot_pin_i[s*4 + p];
      end
    end
  end

  always_comb begin
    line_o = '0;
    for (int s = 0; s < N_SLOTS; s++) line_o |= rot[s];
  end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_router_pkg::*;
#(
  parameter logic [7:0] BASE = 8'h60
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [7:0]                   addr_i,
  input  logic [31:0]                  wdata_i,
  input  logic [3:0]                   be_i,
  output logic [31:0]                  rdata_o,
  output logic [NUM_LINES*ROUTE_W-1:0] route_o
);
  logic hit;
  assign hit = (addr_i & 8'hFC) == (BASE & 8'hFC);

  for (genvar b = 0; b < NUM_LINES; b++) begin : g_byte
    route_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   q <= ROUTE_RST;
      else if (we_i && hit && be_i[b]) q <= wdata_i[b*8 +: 8];
    end
    assign route_o[b*ROUTE_W +: ROUTE_W] = q;
  end

  assign rdata_o = hit ? route_o : 32'h0;
endmodule

// File: rtl/pirq_irq_merge.sv
module pirq_irq_merge
  import pirq_router_pkg::*;
#(
  parameter int unsigned N_OUT = 16
) (
  input  logic [NUM_LINES-1:0]         line_i,
  input  logic [NUM_LINES*ROUTE_W-1:0] route_i,
  output logic [N_OUT-1:0]             irq_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [NUM_LINES-1:0] sel;
    for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
      assign sel[j] = line_i[j] && (route_i[j*ROUTE_W +: ROUTE_W] == ROUTE_W'(o));
    end
    assign irq_o[o] = |sel;
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned N_OUT   = 16,
  parameter logic [7:0]  BASE    = 8'h60
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [7:0]           reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  input  logic [3:0]           reg_be_i,
  output logic [31:0]          reg_rdata_o,
  input  logic [N_SLOTS*8-1:0] slot_devfn_i,
  input  logic [N_SLOTS*4-1:0] slot_pin_i,
  output logic [N_OUT-1:0]     irq_o
);
  logic [NUM_LINES-1:0]         line_d;
  logic [NUM_LINES-1:0]         pirq_lvl_q;
  logic [NUM_LINES*ROUTE_W-1:0] route_flat;

  pirq_swizzle #(.N_SLOTS(N_SLOTS)) u_swz (
    .slot_devfn_i(slot_devfn_i),
    .slot_pin_i  (slot_pin_i),
    .line_o      (line_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pirq_lvl_q <= '0;
    else         pirq_lvl_q <= line_d;
  end

  pirq_route_regs #(.BASE(BASE)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .be_i   (reg_be_i),
    .rdata_o(reg_rdata_o),
    .route_o(route_flat)
  );

  pirq_irq_merge #(.N_OUT(N_OUT)) u_merge (
    .line_i (pirq_lvl_q),
    .route_i(route_flat),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_router_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned N_OUT   = 16
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         reg_we_i,
  input logic [3:0]                   reg_be_i,
  input logic [N_SLOTS*4-1:0]         slot_pin_i,
  input logic [NUM_LINES-1:0]         pirq_lvl_q,
  input logic [NUM_LINES*ROUTE_W-1:0] route_flat,
  input logic [N_OUT-1:0]             irq_o
);
  logic all_off;
  always_comb begin
    all_off = 1'b1;
    for (int j = 0; j < NUM_LINES; j++)
      if (route_flat[j*ROUTE_W +: ROUTE_W] < ROUTE_W'(N_OUT)) all_off = 1'b0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i) !rst_ni |-> irq_o == '0);
  assert_reset_clear_R9: assert property (@(posedge clk_i) !rst_ni |-> pirq_lvl_q == '0);
  assert_unrouted_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_off |-> irq_o == '0);
  assert_fanout_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= $countones(pirq_lvl_q));
  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pirq_lvl_q == '0 |-> irq_o == '0);
  assert_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(slot_pin_i) == '0 |-> pirq_lvl_q == '0);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i || reg_be_i == 4'h0) |=> $stable(route_flat));
endmodule

bind pirq_router pirq_router_chk #(.N_SLOTS(N_SLOTS), .N_OUT(N_OUT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_we_i  (reg_we_i),
  .reg_be_i  (reg_be_i),
  .slot_pin_i(slot_pin_i),
  .pirq_lvl_q(pirq_lvl_q),
  .route_flat(route_flat),
  .irq_o     (irq_o)
);

// File: tb/tb_pirq_router.sv
module tb_pirq_router;
  localparam int NS = 4;
  localparam int NO = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [7:0]    reg_addr_i = 8'h60;
  logic [31:0]   reg_wdata_i = '0;
  logic [3:0]    reg_be_i = '0;
  logic [31:0]   reg_rdata_o;
  logic [NS*8-1:0] slot_devfn_i = {8'h00, 8'h18, 8'h10, 8'h08};
  logic [NS*4-1:0] slot_pin_i = '0;
  logic [NO-1:0] irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pirq_router #(.N_SLOTS(NS), .N_OUT(NO)) dut (.*);

  // behavioural reference
  int rt [4];
  bit lvl [4];
  bit nl [4];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < 4; j++) begin rt[j] = 128; lvl[j] = 0; end
    end else begin
      for (int j = 0; j < 4; j++) nl[j] = 0;
      for (int s = 0; s < NS; s++)
        for (int p = 0; p < 4; p++)
          if (slot_pin_i[s*4+p]) nl[(p + int'(slot_devfn_i[s*8 +: 8] >> 3) + 3) % 4] = 1;
      if (reg_we_i && (reg_addr_i >> 2) == (8'h60 >> 2))
        for (int b = 0; b < 4; b++) if (reg_be_i[b]) rt[b] = int'(reg_wdata_i[b*8 +: 8]);
      for (int j = 0; j < 4; j++) lvl[j] = nl[j];
    end
  end

  function automatic logic [NO-1:0] model_irq();
    logic [NO-1:0] r = '0;
    for (int j = 0; j < 4; j++) if (lvl[j] && rt[j] < NO) r[rt[j]] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i)
    if (rst_ni && !done) chk("R5 model compare", 32'(irq_o), 32'(model_irq()));

  task automatic step();
    @(posedge clk_i); #2;
    reg_we_i = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    reg_addr_i = a; reg_wdata_i = d; reg_be_i = be; reg_we_i = 1'b1;
    step();
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    reg_addr_i = a; #1;
    chk(tag, reg_rdata_o, exp);
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    rd("R1 reset routes", 8'h60, 32'h8080_8080);
    chk("R1 reset irq", 32'(irq_o), 0);

    slot_pin_i = 16'h0001; step();
    chk("R4 unrouted 0x80", 32'(irq_o), 0);

    wr(8'h60, 32'h0C0B_0A09, 4'hF);
    chk("R8 route applies at once", 32'(irq_o), 32'h200);
    rd("R6 readback", 8'h60, 32'h0C0B_0A09);

    slot_pin_i = 16'h1000; step();
    chk("R2 devfn 0 wraps to line 3", 32'(irq_o), 32'h1000);
    slot_pin_i = 16'h0400; step();
    chk("R2 slot2 pin C to line 0", 32'(irq_o), 32'h200);

    slot_pin_i = 16'h0012; step();
    chk("R3 two slots one line", 32'(irq_o), 32'h400);
    slot_pin_i = 16'h0010; step();
    chk("R3 one slot still holds", 32'(irq_o), 32'h400);

    slot_pin_i = 16'h1000; #1;
    chk("R7 before edge", 32'(irq_o), 32'h400);
    step();
    chk("R7 after edge", 32'(irq_o), 32'h1000);

    wr(8'h62, 32'h550A_5555, 4'b0100);
    rd("R6 lane mask, low offset bits ignored", 8'h60, 32'h0C0A_0A09);

    slot_pin_i = 16'h0006; step();
    chk("R5 two lines merged", 32'(irq_o), 32'h400);
    slot_pin_i = 16'h0004; step();
    chk("R5 one line left", 32'(irq_o), 32'h400);
    slot_pin_i = 16'h1001; step();
    chk("R5 separate outputs", 32'(irq_o), 32'h1200);

    wr(8'h64, 32'hFFFF_FFFF, 4'hF);
    rd("R6 other word reads 0", 8'h64, 32'h0);
    rd("R6 other word write ignored", 8'h60, 32'h0C0A_0A09);
    chk("R6 irq unchanged", 32'(irq_o), 32'h1200);

    slot_pin_i = 16'h0001; step();
    wr(8'h60, 32'h0000_0010, 4'b0001);
    chk("R4 value 16 drives none", 32'(irq_o), 0);
    wr(8'h60, 32'h0000_000F, 4'b0001);
    chk("R4 value 15", 32'(irq_o), 32'h8000);
    wr(8'h60, 32'h0000_0000, 4'b0001);
    chk("R4 value 0", 32'(irq_o), 32'h1);
    wr(8'h60, 32'h0000_0003, 4'b0001);
    chk("R8 reroute moves irq", 32'(irq_o), 32'h8);

    slot_pin_i = 16'hFFFF; step(); step();
    rst_ni = 1'b0; #1;
    chk("R9 reset clears levels", 32'(irq_o), 0);
    step();
    rst_ni = 1'b1; #1;
    chk("R9 held pins after reset, not yet latched", 32'(irq_o), 0);
    rd("R9 routes restored", 8'h60, 32'h8080_8080);
    slot_pin_i = '0; step();

    for (int i = 0; i < 400; i++) begin
      slot_pin_i = 16'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        reg_addr_i  = ($urandom_range(0, 3) == 0) ? 8'h68 : 8'(8'h60 + $urandom_range(0, 3));
        reg_wdata_i = {3'($urandom), 5'($urandom), 3'($urandom), 5'($urandom),
                       3'($urandom), 5'($urandom), 3'($urandom), 5'($urandom)};
        reg_be_i    = 4'($urandom);
        reg_we_i    = 1'b1;
      end
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule